// File: doc/BRIEF.md
# Programmable Stage Interval Timer

This block is a synchronous interval timer built on a 24-stage binary counter. A slow, possibly asynchronous timer clock is brought into the system clock domain. Each falling edge of it, once detected, advances the counter by one. A 4-bit select code, together with a bypass input, picks one counter stage to drive the single decode output. With the one-shot disabled, that output is a square wave at the timer-clock rate divided by a power of two. With the one-shot enabled, each rising edge of the chosen stage produces a pulse whose width is given in system clocks.

Three controls prepare the counter. A clear control zeroes the counter and drives the output low. A preset control zeroes the counter and drives the output high through a conditioning latch. After preset is released, one timer edge is used to drop the output before counting starts. Two hold inputs freeze the count while the timer clock keeps running. A test mode splits the counter into three 8-bit sections that count side by side, so every stage can be filled with ones in 255 edges.

Top module: `prog_stage_timer`

## Requirements
- R1: Each falling edge of `tclk_i` advances the counter by exactly one. Stage 1 is the least significant counter bit. The bench reads the counter back by sweeping the stage select.
- R2: With `skip8_i` low, select code k (0..15) routes stage k+9 to `decode_o`. With `skip8_i` high, the same code routes stage k+1.
- R3: While `clear_i` is high, the counter is zero and `decode_o` is low. When `clear_i` and `preset_i` are both high with `skip8_i` low, the clear wins. In that case, once both are released, the very next falling edge counts.
- R4: While `preset_i` is high (and `clear_i` is low), the counter is zero and `decode_o` is high. After release, the first falling edge drives `decode_o` low without counting, and the second falling edge counts 1.
- R5: While `cnt_hold_i` or `src_hold_i` is high, falling edges are ignored and the count is kept. The first falling edge after both are low counts again.
- R6: With `oneshot_en_i` low, `decode_o` equals the selected stage. After a clear, stage n first goes high on falling edge 2^(n-1) and then toggles every 2^(n-1) edges.
- R7: With `skip8_i`, `preset_i` and `clear_i` all high, the counter works as three independent 8-bit sections clocked together. After 255 edges every stage reads 1. After `preset_i` and `clear_i` drop together, one more edge wraps all 24 stages to 0.
- R8: With `oneshot_en_i` high, a rising edge of the selected stage makes `decode_o` high for exactly `width_i` system clocks. A width of 0 produces no pulse.
- R9: A new rising edge of the selected stage during an active pulse reloads the width, so the pulse is stretched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of all registers |
| tclk_i | input | 1 | Timer clock; counting happens on its falling edges |
| clear_i | input | 1 | Zeroes the counter and forces the output low |
| preset_i | input | 1 | Zeroes the counter and forces the output high |
| skip8_i | input | 1 | Skips the first 8 stages in stage selection; with both controls high, selects test mode |
| sel_i | input | 4 | Stage select code |
| cnt_hold_i | input | 1 | Freezes the count |
| src_hold_i | input | 1 | Second hold input, same effect as cnt_hold_i |
| oneshot_en_i | input | 1 | Turns the output into a one-shot pulse |
| width_i | input | 8 | One-shot width in system clocks |
| decode_o | output | 1 | Decode output |

## Verification
The counter is driven with short edge bursts and then read back one bit at a time by sweeping the select code. This separates an off-by-one count from a wrong stage mapping. Long bursts of 255 and 256 edges separate the two select ranges: the upper stages flip only at the byte boundary. Bursts with holds, presets and clears mixed in separate an edge that is ignored from one that is counted. The split-counter run checks that all sections fill at once and wrap together. One-shot runs use a single isolated rising edge, a zero width and a stage that re-rises faster than the width. These tell an exact width, a suppressed pulse and a reload apart.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    localparam int unsigned STAGE_COUNT  = 24;
    localparam int unsigned SECTION_LEN  = 8;
    localparam int unsigned SEL_BITS     = 4;
    localparam int unsigned WIDTH_BITS   = 8;
    localparam int unsigned SYNC_DEPTH   = 2;

    typedef enum logic [2:0] {
        MODE_RUN,
        MODE_HOLD,
        MODE_CLEAR_LO,
        MODE_CLEAR_HI,
        MODE_SPLIT
    } core_mode_e;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC-1:0] sh;
        logic            last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[SYNC-2:0], async_i};
        s_d.last = s_q.sh[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fall_o = s_q.last & ~s_q.sh[SYNC-1];

endmodule

// File: rtl/tmr_stage_core.sv
module tmr_stage_core
    import prog_timer_pkg::*;
#(
    parameter int unsigned STAGES  = 24,
    parameter int unsigned SECTION = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  core_mode_e        mode_i,
    output logic [STAGES-1:0] cnt_o,
    output logic              latch_o
);
    localparam int unsigned NSEC = STAGES / SECTION;
    localparam logic [SECTION-1:0] SEC_ONE = {{(SECTION-1){1'b0}}, 1'b1};
    localparam logic [STAGES-1:0]  CNT_ONE = {{(STAGES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              latch;
        logic              armed;
    } core_t;

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (mode_i)
            MODE_SPLIT: begin
                c_d.latch = 1'b0;
                c_d.armed = 1'b0;
                if (adv_i) begin
                    for (int s = 0; s < NSEC; s++) begin
                        c_d.cnt[s*SECTION +: SECTION] = c_q.cnt[s*SECTION +: SECTION] + SEC_ONE;
                    end
                end
            end
            MODE_CLEAR_LO: begin
                c_d.cnt   = '0;
                c_d.latch = 1'b0;
                c_d.armed = 1'b0;
            end
            MODE_CLEAR_HI: begin
                c_d.cnt   = '0;
                c_d.latch = 1'b1;
                c_d.armed = 1'b1;
            end
            MODE_HOLD: begin
                c_d = c_q;
            end
            default: begin
                if (adv_i) begin
                    if (c_q.armed) begin
                        c_d.armed = 1'b0;
                        c_d.latch = 1'b0;
                    end else begin
                        c_d.cnt = c_q.cnt + CNT_ONE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o   = c_q.cnt;
    assign latch_o = c_q.latch;

endmodule

// File: rtl/tmr_stage_mux.sv
module tmr_stage_mux #(
    parameter int unsigned STAGES  = 24,
    parameter int unsigned SECTION = 8,
    parameter int unsigned SEL_W   = 4
) (
    input  logic [STAGES-1:0] cnt_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              skip_i,
    output logic              stage_o
);
    localparam int unsigned IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = skip_i ? IDX_W'(sel_i) : IDX_W'(sel_i) + IDX_W'(SECTION);
        stage_o = cnt_i[idx];
    end

endmodule

// File: rtl/tmr_one_shot.sv
module tmr_one_shot #(
    parameter int unsigned PW_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            en_i,
    input  logic            stage_i,
    input  logic [PW_W-1:0] width_i,
    output logic            active_o
);
    localparam logic [PW_W-1:0] PW_ONE = {{(PW_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic            prev;
        logic [PW_W-1:0] left;
    } shot_t;

    shot_t p_d, p_q;

    always_comb begin
        p_d      = p_q;
        p_d.prev = stage_i;
        if (clr_i) begin
            p_d.left = '0;
        end else if (en_i && stage_i && !p_q.prev) begin
            p_d.left = width_i;
        end else if (p_q.left != '0) begin
            p_d.left = p_q.left - PW_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign active_o = (p_q.left != '0);

endmodule

// File: rtl/prog_stage_timer.sv
module prog_stage_timer
    import prog_timer_pkg::*;
#(
    parameter int unsigned STAGES  = STAGE_COUNT,
    parameter int unsigned SECTION = SECTION_LEN,
    parameter int unsigned SEL_W   = SEL_BITS,
    parameter int unsigned PW_W    = WIDTH_BITS,
    parameter int unsigned SYNC    = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tclk_i,
    input  logic             clear_i,
    input  logic             preset_i,
    input  logic             skip8_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             cnt_hold_i,
    input  logic             src_hold_i,
    input  logic             oneshot_en_i,
    input  logic [PW_W-1:0]  width_i,
    output logic             decode_o
);
    logic              adv;
    core_mode_e        mode;
    logic [STAGES-1:0] cnt_w;
    logic              latch_w;
    logic              stage_w;
    logic              shot_w;
    logic              shot_clr;

    tmr_edge_sync #(.SYNC(SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tclk_i),
        .fall_o  (adv)
    );

    always_comb begin
        if (skip8_i && preset_i && clear_i) mode = MODE_SPLIT;
        else if (clear_i)                   mode = MODE_CLEAR_LO;
        else if (preset_i)                  mode = MODE_CLEAR_HI;
        else if (cnt_hold_i || src_hold_i)  mode = MODE_HOLD;
        else                                mode = MODE_RUN;
        shot_clr = (mode == MODE_CLEAR_LO) || (mode == MODE_CLEAR_HI);
    end

    tmr_stage_core #(.STAGES(STAGES), .SECTION(SECTION)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .mode_i  (mode),
        .cnt_o   (cnt_w),
        .latch_o (latch_w)
    );

    tmr_stage_mux #(.STAGES(STAGES), .SECTION(SECTION), .SEL_W(SEL_W)) u_mux (
        .cnt_i   (cnt_w),
        .sel_i   (sel_i),
        .skip_i  (skip8_i),
        .stage_o (stage_w)
    );

    tmr_one_shot #(.PW_W(PW_W)) u_shot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (shot_clr),
        .en_i     (oneshot_en_i),
        .stage_i  (stage_w),
        .width_i  (width_i),
        .active_o (shot_w)
    );

    assign decode_o = latch_w | (oneshot_en_i ? shot_w : stage_w);

endmodule

// File: rtl/prog_stage_timer_chk.sv
module prog_stage_timer_chk #(
    parameter int unsigned STAGES  = 24,
    parameter int unsigned SECTION = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              preset_i,
    input logic              skip8_i,
    input logic              cnt_hold_i,
    input logic              src_hold_i,
    input logic [STAGES-1:0] cnt,
    input logic              decode_o
);
    localparam logic [STAGES-1:0]  C_ONE = {{(STAGES-1){1'b0}}, 1'b1};
    localparam logic [SECTION-1:0] S_ONE = {{(SECTION-1){1'b0}}, 1'b1};

    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !preset_i) |=> (cnt == $past(cnt) || cnt == $past(cnt) + C_ONE));

    a_r3_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !(skip8_i && preset_i)) |=> (cnt == '0 && !decode_o));

    a_r4_preset_high: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_i && !clear_i) |=> (cnt == '0 && decode_o));

    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !preset_i && (cnt_hold_i || src_hold_i)) |=> $stable(cnt));

    a_r7_section_step: assert property (@(posedge clk) disable iff (!rst_n)
        (skip8_i && preset_i && clear_i) |=>
            (cnt == $past(cnt) || cnt[SECTION-1:0] == $past(cnt[SECTION-1:0]) + S_ONE));

endmodule

bind prog_stage_timer prog_stage_timer_chk #(.STAGES(STAGES), .SECTION(SECTION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .preset_i   (preset_i),
    .skip8_i    (skip8_i),
    .cnt_hold_i (cnt_hold_i),
    .src_hold_i (src_hold_i),
    .cnt        (cnt_w),
    .decode_o   (decode_o)
);

// File: tb/prog_stage_timer_tb.sv
module prog_stage_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tclk_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       preset_i = 1'b0;
    logic       skip8_i = 1'b0;
    logic [3:0] sel_i = 4'd0;
    logic       cnt_hold_i = 1'b0;
    logic       src_hold_i = 1'b0;
    logic       oneshot_en_i = 1'b0;
    logic [7:0] width_i = 8'd0;
    logic       decode_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    prog_stage_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tclk_i       (tclk_i),
        .clear_i      (clear_i),
        .preset_i     (preset_i),
        .skip8_i      (skip8_i),
        .sel_i        (sel_i),
        .cnt_hold_i   (cnt_hold_i),
        .src_hold_i   (src_hold_i),
        .oneshot_en_i (oneshot_en_i),
        .width_i      (width_i),
        .decode_o     (decode_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic falls(input int n);
        for (int i = 0; i < n; i++) begin
            tclk_i = 1'b1; cyc(4);
            tclk_i = 1'b0; cyc(4);
        end
    endtask

    task automatic read_count(output logic [23:0] v);
        logic       sb = skip8_i;
        logic [3:0] ss = sel_i;
        v = '0;
        skip8_i = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sel_i = 4'(i); #1; v[i] = decode_o; cyc(1);
        end
        skip8_i = 1'b0;
        for (int i = 8; i < 16; i++) begin
            sel_i = 4'(i); #1; v[i+8] = decode_o; cyc(1);
        end
        skip8_i = sb; sel_i = ss; #1;
    endtask

    task automatic do_clear();
        clear_i = 1'b1; cyc(2); clear_i = 1'b0; cyc(1);
    endtask

    task automatic t_reset_state();
        logic [23:0] v;
        #1; check("R3 reset output", decode_o, 0);
        read_count(v); check("R3 reset count", v, 0);
    endtask

    task automatic t_count();
        logic [23:0] v;
        do_clear(); falls(5);
        read_count(v); check("R1 five edges", v, 5);
        falls(6);
        read_count(v); check("R1 eleven edges", v, 11);
    endtask

    task automatic t_select();
        do_clear(); skip8_i = 1'b0; sel_i = 4'd0;
        falls(255); #1; check("R2 stage9 before 256", decode_o, 0);
        falls(1);   #1; check("R2 stage9 at 256", decode_o, 1);
        sel_i = 4'd1; #1; check("R2 stage10 at 256", decode_o, 0);
        skip8_i = 1'b1; sel_i = 4'd8; #1; check("R2 skip code8 stage9", decode_o, 1);
        sel_i = 4'd0; #1; check("R2 skip code0 stage1", decode_o, 0);
        skip8_i = 1'b0; cyc(1);
    endtask

    task automatic t_square();
        skip8_i = 1'b1; sel_i = 4'd2; do_clear();
        for (int e = 1; e <= 12; e++) begin
            falls(1); #1;
            check($sformatf("R6 stage3 edge %0d", e), decode_o, (e >> 2) & 1);
        end
        skip8_i = 1'b0; sel_i = 4'd0; cyc(1);
    endtask

    task automatic t_preset();
        logic [23:0] v;
        do_clear(); falls(3);
        preset_i = 1'b1; cyc(2); #1;
        check("R4 preset high", decode_o, 1);
        preset_i = 1'b0; cyc(2); #1;
        check("R4 high after release", decode_o, 1);
        falls(1); #1;
        check("R4 first edge drops output", decode_o, 0);
        read_count(v); check("R4 first edge no count", v, 0);
        falls(1);
        read_count(v); check("R4 second edge counts", v, 1);
    endtask

    task automatic t_clear_priority();
        logic [23:0] v;
        do_clear(); falls(2);
        skip8_i = 1'b0; clear_i = 1'b1; preset_i = 1'b1; cyc(2); #1;
        check("R3 clear beats preset", decode_o, 0);
        clear_i = 1'b0; preset_i = 1'b0; cyc(2);
        falls(1);
        read_count(v); check("R3 next edge counts", v, 1);
    endtask

    task automatic t_hold();
        logic [23:0] v;
        do_clear(); falls(3);
        cnt_hold_i = 1'b1; falls(4);
        read_count(v); check("R5 count hold", v, 3);
        cnt_hold_i = 1'b0; falls(1);
        read_count(v); check("R5 resume after count hold", v, 4);
        src_hold_i = 1'b1; falls(2);
        read_count(v); check("R5 source hold", v, 4);
        src_hold_i = 1'b0; falls(1);
        read_count(v); check("R5 resume after source hold", v, 5);
    endtask

    task automatic t_split();
        logic [23:0] v;
        do_clear();
        clear_i = 1'b1; preset_i = 1'b1; cyc(1); skip8_i = 1'b1; cyc(2);
        falls(254);
        sel_i = 4'd0; #1; check("R7 stage1 at 254", decode_o, 0);
        sel_i = 4'd7; #1; check("R7 stage8 at 254", decode_o, 1);
        falls(1);
        sel_i = 4'd0;  #1; check("R7 stage1 at 255", decode_o, 1);
        sel_i = 4'd15; #1; check("R7 stage16 at 255", decode_o, 1);
        cyc(1); clear_i = 1'b0; preset_i = 1'b0; cyc(2);
        read_count(v); check("R7 all ones", v, 24'hFFFFFF);
        falls(1);
        read_count(v); check("R7 wrap to zero", v, 0);
        skip8_i = 1'b0; sel_i = 4'd0;
    endtask

    task automatic measure(output int hi);
        hi = 0;
        tclk_i = 1'b1; cyc(4);
        tclk_i = 1'b0;
        for (int i = 0; i < 30; i++) begin
            cyc(1); if (decode_o) hi++;
        end
    endtask

    task automatic t_oneshot();
        int hi;
        do_clear();
        oneshot_en_i = 1'b1; width_i = 8'd5; skip8_i = 1'b1; sel_i = 4'd1;
        falls(1);
        measure(hi); check("R8 pulse width 5", hi, 5);
        width_i = 8'd0; falls(3);
        measure(hi); check("R8 width zero no pulse", hi, 0);
    endtask

    task automatic t_retrigger();
        int lo = 0;
        do_clear();
        oneshot_en_i = 1'b1; width_i = 8'd20; skip8_i = 1'b1; sel_i = 4'd0;
        falls(1);
        for (int i = 0; i < 6; i++) begin
            tclk_i = 1'b1;
            for (int k = 0; k < 4; k++) begin cyc(1); if (!decode_o) lo++; end
            tclk_i = 1'b0;
            for (int k = 0; k < 4; k++) begin cyc(1); if (!decode_o) lo++; end
        end
        check("R9 reload keeps output high", lo, 0);
        cyc(40); #1;
        check("R9 pulse ends after last reload", decode_o, 0);
        oneshot_en_i = 1'b0; width_i = 8'd0; skip8_i = 1'b0;
    endtask

    initial begin
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset_state();
        t_count();
        t_select();
        t_square();
        t_preset();
        t_clear_priority();
        t_hold();
        t_split();
        t_oneshot();
        t_retrigger();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule